// File: doc/BRIEF.md
# Configurable Parallel Host Port

This block is a slave parallel port between an external host bus and an internal processor. Two 16-bit holding registers carry the data: the host fills the inbound register and the processor drains it, while the processor fills the outbound register and the host drains it. The processor reaches both registers through one data address. A read returns the inbound register and a write loads the outbound register. Two flags track the buffers: inbound-full and outbound-empty.

A 16-bit control word, written by the processor, sets the personality of the host side. It chooses one of two strobing schemes. The first uses separate write and read strobes. The second uses a direction line plus a single data strobe whose polarity can be chosen. The control word also picks 8-bit or 16-bit transfers, the sense of the byte-select pin, the polarity of both flag pins, a merged flag on the full pin, and the sense of the empty bit in the host-visible status word. A status-select pin lets the host read that status word in place of the data.

Host strobes are sampled into the processor clock through a two-flop synchronizer. A transfer completes on the trailing edge of its strobe. The host therefore has to hold its data, byte-select and status-select levels until the completion has been registered.

Top module: `par_host_port`

## Requirements
- R1: After reset the control word reads 0, flag_ibf is 0, flag_obe is 1, and with h_stsel high h_dout reads 16'h0001.
- R2: A control write stores bits 6..0, and bits 15..7 read back as 0. The bit map is: 0 wide, 1 direction-line scheme, 2 data-strobe polarity, 3 byte-select sense, 4 flag-pin polarity, 5 flag merge, 6 status empty-bit inversion. For SYNC+1 cycles after a control write or reset, strobe activity is discarded.
- R3: cpu_rdata always shows the inbound register. A cpu_wr pulse loads cpu_wdata into the outbound register, which the host then reads.
- R4: With bit 1 clear, h_strb_a low is a host write and h_strb_b low is a host read. Each transfer takes effect on the third rising clock edge after its strobe rises.
- R5: With bit 1 set, h_strb_b is the data strobe, active low when bit 2 is 0 and active high when bit 2 is 1. h_strb_a high marks a read and low marks a write. Completion timing is the same as in R4.
- R6: With bit 0 set, every host access moves a full 16-bit word on h_din or h_dout and completes the transfer.
- R7: With bit 0 clear, the host moves bytes on h_din[7:0] and h_dout[7:0], and h_dout[15:8] reads 0. A low-byte access leaves both flags unchanged. A high-byte access completes the transfer.
- R8: The low byte is selected when h_bsel equals bit 3 of the control word, and the high byte is selected otherwise.
- R9: Inbound-full sets when a host write transfer completes and clears on cpu_rd. If both happen in the same cycle, it stays set.
- R10: Outbound-empty clears on cpu_wr and sets when a host read transfer completes. If both happen in the same cycle, it stays clear.
- R11: A host read with h_stsel high returns 16'h0000 with inbound-full in bit 1 and the empty status in bit 0, and changes no flag.
- R12: Control bit 6 set inverts the empty bit of the status word only.
- R13: Control bit 4 set drives both flag pins active low. Clear drives them active high.
- R14: Control bit 5 set drives flag_ibf from inbound-full OR outbound-empty. flag_obe is unchanged by this bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| ctl_q | output | 16 | Control word readback |
| cpu_rd | input | 1 | Processor read of the inbound register |
| cpu_wr | input | 1 | Processor write of the outbound register |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Inbound register contents |
| h_strb_a | input | 1 | Host write strobe, or direction line |
| h_strb_b | input | 1 | Host read strobe, or data strobe |
| h_bsel | input | 1 | Host byte select |
| h_stsel | input | 1 | Host status select |
| h_din | input | 16 | Host write data |
| h_dout | output | 16 | Host read data |
| flag_ibf | output | 1 | Inbound-full flag pin |
| flag_obe | output | 1 | Outbound-empty flag pin |

## Verification
On every cycle, the assertions check how the two buffer flags respond to processor accesses and to completed host transfers, including which side wins when both land together. They also check that a status read leaves the empty flag alone, that the control word and outbound register hold when not written, and that the post-write blanking window suppresses pending strobes. Only the bench scenarios can show the decoding of both strobing schemes under every polarity, the byte-lane routing under both select senses, the status-word layout and its inversion, and the flag-pin polarity and merging. The bench sweeps all 128 control settings to cover these.

// File: rtl/par_host_port.sv
`timescale 1ns/1ps
module par_host_port #(
  parameter int DW   = 16,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [DW-1:0] ctl_wdata,
  output logic [DW-1:0] ctl_q,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          h_strb_a,
  input  logic          h_strb_b,
  input  logic          h_bsel,
  input  logic          h_stsel,
  input  logic [DW-1:0] h_din,
  output logic [DW-1:0] h_dout,
  output logic          flag_ibf,
  output logic          flag_obe
);
  localparam int HB     = DW / 2;
  localparam int NCTL   = 7;
  localparam int GW     = $clog2(SYNC + 2);
  localparam logic [DW-1:0] CMASK = DW'((1 << NCTL) - 1);
  localparam logic [GW-1:0] GLOAD = GW'(SYNC + 1);
  localparam int C_WIDE = 0, C_MOTO = 1, C_DSPOL = 2, C_BSENSE = 3;
  localparam int C_FPOL = 4, C_MERGE = 5, C_SINV = 6;

  logic [DW-1:0]   ctl, ibuf, obuf;
  logic            ibf, obe;
  logic [SYNC-1:0] sa, sb;
  logic [GW-1:0]   guard;
  logic            wr_q, rd_q;
  logic            a_s, b_s, ds_on, wr_act, rd_act;
  logic            wr_end, rd_end, lo_sel, wr_last, rd_last;
  logic [DW-1:0]   status, rd_word;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ctl <= '0;
    else if (ctl_we) ctl <= ctl_wdata & CMASK;

  assign ctl_q = ctl;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sa <= '1;
      sb <= '1;
    end else begin
      sa <= {sa[SYNC-2:0], h_strb_a};
      sb <= {sb[SYNC-2:0], h_strb_b};
    end

  assign a_s   = sa[SYNC-1];
  assign b_s   = sb[SYNC-1];
  assign ds_on = ctl[C_DSPOL] ? b_s : ~b_s;

  assign wr_act = ctl[C_MOTO] ? (ds_on & ~a_s) : ~a_s;
  assign rd_act = ctl[C_MOTO] ? (ds_on &  a_s) : ~b_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          guard <= GLOAD;
    else if (ctl_we)     guard <= GLOAD;
    else if (guard != 0) guard <= guard - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else if (guard != 0 || ctl_we) begin
      wr_q <= 1'b0;
      rd_q <= 1'b0;
    end else begin
      wr_q <= wr_act;
      rd_q <= rd_act;
    end

  assign wr_end  = wr_q & ~wr_act;
  assign rd_end  = rd_q & ~rd_act;
  assign lo_sel  = (h_bsel == ctl[C_BSENSE]);
  assign wr_last = wr_end & (ctl[C_WIDE] | ~lo_sel);
  assign rd_last = rd_end & ~h_stsel & (ctl[C_WIDE] | ~lo_sel);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ibuf <= '0;
    else if (wr_end) begin
      if (ctl[C_WIDE]) ibuf <= h_din;
      else if (lo_sel) ibuf[HB-1:0] <= h_din[HB-1:0];
      else ibuf[DW-1:HB] <= h_din[HB-1:0];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       ibf <= 1'b0;
    else if (wr_last) ibf <= 1'b1;
    else if (cpu_rd)  ibf <= 1'b0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      obuf <= '0;
    else if (cpu_wr) obuf <= cpu_wdata;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       obe <= 1'b1;
    else if (cpu_wr)  obe <= 1'b0;
    else if (rd_last) obe <= 1'b1;

  assign cpu_rdata = ibuf;
  assign status    = DW'({ibf, obe ^ ctl[C_SINV]});
  assign rd_word   = ctl[C_WIDE] ? obuf
                   : (lo_sel ? DW'(obuf[HB-1:0]) : DW'(obuf[DW-1:HB]));
  assign h_dout    = h_stsel ? status : rd_word;

  assign flag_ibf = (ctl[C_MERGE] ? (ibf | obe) : ibf) ^ ctl[C_FPOL];
  assign flag_obe = obe ^ ctl[C_FPOL];

  p_ctl_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_we |=> $stable(ctl_q));

  p_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (guard != 0) |=> (!wr_end && !rd_end));

  p_obuf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_wr |=> $stable(obuf));

  p_ibf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_last |=> ibf);

  p_ibf_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_rd && !wr_last) |=> !ibf);

  p_obe_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wr |=> !obe);

  p_obe_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_last && !cpu_wr) |=> obe);

  p_stat_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_end && h_stsel && !cpu_wr) |=> $stable(obe));
endmodule

// File: tb/par_host_port_tb.sv
`timescale 1ns/1ps
module par_host_port_tb;
  logic        clk, rst_n;
  logic        ctl_we, cpu_rd, cpu_wr;
  logic [15:0] ctl_wdata, ctl_q, cpu_wdata, cpu_rdata, h_din, h_dout;
  logic        h_strb_a, h_strb_b, h_bsel, h_stsel, flag_ibf, flag_obe;

  int vectors = 0, miscompares = 0;
  logic [6:0]  cfg;
  logic        m_ibf, m_obe;
  logic [15:0] m_ibuf, m_obuf, seen, d, e;

  par_host_port #(.DW(16), .SYNC(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_q(ctl_q), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata), .h_strb_a(h_strb_a), .h_strb_b(h_strb_b),
    .h_bsel(h_bsel), .h_stsel(h_stsel), .h_din(h_din), .h_dout(h_dout),
    .flag_ibf(flag_ibf), .flag_obe(flag_obe));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s (cfg %02h): got %h expected %h", tag, cfg, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_stat();
    return {14'b0, m_ibf, m_obe ^ cfg[6]};
  endfunction

  function automatic logic [15:0] exp_pins();
    logic pi;
    pi = (cfg[5] ? (m_ibf | m_obe) : m_ibf) ^ cfg[4];
    return {14'b0, pi, m_obe ^ cfg[4]};
  endfunction

  task automatic chk_pins(input string tag);
    chk(tag, {14'b0, flag_ibf, flag_obe}, exp_pins());
  endtask

  task automatic write_ctl(input logic [6:0] c, input logic [8:0] junk);
    @(negedge clk);
    cfg = c;
    ctl_we = 1'b1;
    ctl_wdata = {junk, c};
    h_strb_a = 1'b1;
    h_strb_b = (c[1] & c[2]) ? 1'b0 : 1'b1;
    @(negedge clk);
    ctl_we = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic strobe(input bit wr, input bit on);
    if (!cfg[1]) begin
      if (wr) h_strb_a = ~on;
      else    h_strb_b = ~on;
    end else begin
      if (on) h_strb_a = ~wr;
      h_strb_b = on ? cfg[2] : ~cfg[2];
    end
  endtask

  // coll: 0 none, 1 cpu_rd, 2 cpu_wr in the completing cycle
  task automatic host_xfer(input bit wr, input bit lo, input bit st,
                           input logic [15:0] dat, input int coll,
                           output logic [15:0] got);
    @(negedge clk);
    h_bsel = lo ? cfg[3] : ~cfg[3];
    h_stsel = st;
    h_din = dat;
    strobe(wr, 1'b1);
    repeat (4) @(negedge clk);
    got = h_dout;
    strobe(wr, 1'b0);
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    if (coll == 1) cpu_rd = 1'b1;
    if (coll == 2) cpu_wr = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    cpu_wr = 1'b0;
    repeat (2) @(negedge clk);
    h_stsel = 1'b0;
    h_strb_a = 1'b1;
  endtask

  task automatic pulse_rd();
    @(negedge clk); cpu_rd = 1'b1;
    @(negedge clk); cpu_rd = 1'b0;
    m_ibf = 1'b0;
  endtask

  task automatic pulse_wr(input logic [15:0] v);
    @(negedge clk); cpu_wr = 1'b1; cpu_wdata = v;
    @(negedge clk); cpu_wr = 1'b0;
    m_obuf = v;
    m_obe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    cfg = '0; rst_n = 1'b0; ctl_we = 1'b0; ctl_wdata = '0;
    cpu_rd = 1'b0; cpu_wr = 1'b0; cpu_wdata = '0;
    h_strb_a = 1'b1; h_strb_b = 1'b1; h_bsel = 1'b0; h_stsel = 1'b0; h_din = '0;
    m_ibf = 1'b0; m_obe = 1'b1; m_ibuf = '0; m_obuf = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 control word", ctl_q, 16'h0000);
    chk("R1 flag pins", {14'b0, flag_ibf, flag_obe}, 16'h0001);
    h_stsel = 1'b1;
    @(negedge clk);
    chk("R1 status word", h_dout, 16'h0001);
    h_stsel = 1'b0;

    for (int i = 0; i < 128; i++) begin
      write_ctl(7'(i), 9'h1C5 ^ 9'(i));
      chk("R2 control readback", ctl_q, {9'b0, cfg});
      chk_pins("R13 R14 flag pins after control write");

      host_xfer(1'b0, 1'b1, 1'b1, 16'h0, 0, seen);
      chk("R11 R12 status word", seen, exp_stat());
      chk_pins("R11 status read leaves flags");

      d = 16'hA5C3 ^ {8'(i), ~8'(i)};
      if (cfg[0]) begin
        host_xfer(1'b1, 1'b1, 1'b0, d, 0, seen);
        m_ibuf = d;
      end else begin
        host_xfer(1'b1, 1'b1, 1'b0, {8'hEE, d[7:0]}, 0, seen);
        m_ibuf[7:0] = d[7:0];
        chk("R7 R8 low byte write", cpu_rdata, m_ibuf);
        chk_pins("R7 low byte write leaves flags");
        host_xfer(1'b1, 1'b0, 1'b0, {8'h11, d[15:8]}, 0, seen);
        m_ibuf[15:8] = d[15:8];
      end
      m_ibf = 1'b1;
      chk("R3 R4 R5 R6 R8 inbound data", cpu_rdata, m_ibuf);
      chk_pins("R9 R13 R14 inbound-full set");

      pulse_rd();
      chk_pins("R9 inbound-full cleared by cpu_rd");

      e = ~d ^ 16'h0F0F;
      pulse_wr(e);
      chk_pins("R10 outbound-empty cleared by cpu_wr");

      if (cfg[0]) begin
        host_xfer(1'b0, 1'b1, 1'b0, 16'h0, 0, seen);
        chk("R3 R4 R5 R6 outbound word", seen, e);
      end else begin
        host_xfer(1'b0, 1'b1, 1'b0, 16'h0, 0, seen);
        chk("R7 R8 read low byte", seen, {8'h00, e[7:0]});
        chk_pins("R7 low byte read leaves flags");
        host_xfer(1'b0, 1'b0, 1'b0, 16'h0, 0, seen);
        chk("R7 R8 read high byte", seen, {8'h00, e[15:8]});
      end
      m_obe = 1'b1;
      chk_pins("R10 outbound-empty set by host read");
    end

    // R9 R10 same-cycle collisions, wide separate-strobe scheme
    write_ctl(7'h01, 9'h0);
    host_xfer(1'b1, 1'b1, 1'b0, 16'h1234, 1, seen);
    m_ibuf = 16'h1234; m_ibf = 1'b1;
    chk("R9 write data with colliding read", cpu_rdata, m_ibuf);
    chk_pins("R9 host write beats cpu_rd");
    pulse_rd();
    chk_pins("R9 clear after collision");
    pulse_wr(16'hBEEF);
    cpu_wdata = 16'hCAFE;
    host_xfer(1'b0, 1'b1, 1'b0, 16'h0, 2, seen);
    chk("R10 host sees old outbound word", seen, 16'hBEEF);
    m_obuf = 16'hCAFE; m_obe = 1'b0;
    chk_pins("R10 cpu_wr beats host read");
    host_xfer(1'b0, 1'b1, 1'b0, 16'h0, 0, seen);
    chk("R3 new outbound word", seen, 16'hCAFE);
    m_obe = 1'b1;
    chk_pins("R10 empty after final read");

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule